// File: doc/BRIEF.md
# Auto-Rate Search Sequencer

This block chooses one of four data-rate settings for a clock-recovery loop. In automatic mode, a search is started by a request flag from the frequency-unlock logic. The search then steps the selected rate at a programmable interval in the cyclic order 0, 1, 2, 3, 0, and so on, until the loop reports lock. A later search continues from the rate that was chosen most recently.

In manual mode the block releases the shared two-bit rate bus and takes the rate from it. The oscillator, phase detector, loop filter and frequency detector are not part of this block. They appear only as the `locked` and `seek_req` flags.

A retriggerable carrier timer watches the data-transition strobe. The carrier is present only while transitions arrive at least once per microsecond, and that time is set as a number of clock cycles. When the carrier is missing, the search is inhibited and the rate is held. If muting is enabled, a hold strobe freezes the recovered clock and data.

The controller is a four-state machine:
- `ST_MANUAL`: the rate comes from the bus.
- `ST_IDLE`: automatic mode, not searching.
- `ST_SEEK`: stepping.
- `ST_INHIBIT`: a search is pending but there is no carrier.

The transitions are:
- any state to `ST_MANUAL` when the mode select goes low;
- `ST_MANUAL` to `ST_SEEK` when auto mode is chosen and the carrier is present, or to `ST_INHIBIT` when it is not;
- `ST_IDLE` to `ST_SEEK` or `ST_INHIBIT` on a search request, depending on the carrier;
- `ST_SEEK` to `ST_IDLE` on lock, and to `ST_INHIBIT` when the carrier is lost;
- `ST_INHIBIT` to `ST_IDLE` on lock, and to `ST_SEEK` when the carrier returns.

Top module: `rate_seeker`

## Requirements
- R1: A synchronous active-high reset sets the rate to 0, clears `carrier_ok`, `seeking` and `hold_out`, and enters `ST_IDLE`.
- R2: While in `ST_SEEK`, the carrier is present and the loop is unlocked, the rate increases by one modulo 4 (3 wraps to 0). The first step comes `dwell_cycles` clocks after entry into `ST_SEEK`, and each later step comes `dwell_cycles` clocks after the previous one.
- R3: A search request in `ST_IDLE` resumes stepping from the current rate, not from 0.
- R4: When `locked` is high in `ST_SEEK`, the rate does not change and `seeking` is low from the next clock.
- R5: `carrier_ok` goes high on the clock after a strobe. It stays high for exactly `CYC_PER_US` clocks after the most recent strobe, and each strobe restarts that count.
- R6: Without carrier, the search moves to `ST_INHIBIT` and the rate holds. When the carrier returns, the dwell count starts again from zero.
- R7: `hold_out` is high on the clock after a cycle in which `mute_en` is high and `carrier_ok` is low. Otherwise it is low.
- R8: When `auto_mode` is low, the next clock loads `rate_in` into the rate and clears `rate_drive_en`. In any automatic state, `rate_drive_en` is high.
- R9: A change from manual to automatic mode starts the search from the rate that was loaded manually.
- R10: A `dwell_cycles` value of 0 behaves like 1, so the rate steps on every clock.
- R11: `seeking` is high exactly in `ST_SEEK` and `ST_INHIBIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_strobe | input | 1 | One pulse per data transition |
| locked | input | 1 | Phase lock reported by the loop |
| seek_req | input | 1 | Search request from the frequency-unlock logic |
| auto_mode | input | 1 | 1 = automatic search, 0 = manual rate |
| mute_en | input | 1 | Enables the hold strobe when the carrier is absent |
| rate_in | input | 2 | Rate sampled from the shared bus in manual mode |
| dwell_cycles | input | DWELL_W | Clocks spent on each rate while searching |
| rate_out | output | 2 | Selected rate |
| rate_drive_en | output | 1 | High when the block drives the shared rate bus |
| carrier_ok | output | 1 | Carrier present |
| seeking | output | 1 | Search active or pending |
| hold_out | output | 1 | Freeze strobe for the recovered clock and data |

## Verification
Two events can fall in the same clock: a dwell expiry, and either lock or carrier loss. In that cycle the step must be dropped. The sweep makes this happen by asserting lock, or by removing the strobe, at fixed offsets inside every dwell length from 0 to 4 and from every starting rate. A pseudo-random phase then mixes strobe gaps around the timeout with lock and request pulses. In every clock, each output is compared against an arithmetic model in the bench, so a step taken in a colliding cycle appears as a rate miscompare.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_MANUAL  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_SEEK    = 2'd2,
        ST_INHIBIT = 2'd3
    } rs_state_e;
endpackage

// File: rtl/rs_carrier_timer.sv
module rs_carrier_timer #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_strobe,
    output logic present
);
    localparam int CW = $clog2(CYC_PER_US + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CYC_PER_US);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (edge_strobe)
            left_q <= RELOAD;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign present = (left_q != '0);

    // R5: every transition retriggers the one-shot
    p_retrigger_r5: assert property (@(posedge clk) disable iff (rst)
        edge_strobe |=> present);
    // R5: without transitions the remaining time never grows
    p_no_growth_r5: assert property (@(posedge clk) disable iff (rst)
        !edge_strobe |=> left_q <= $past(left_q));
endmodule

// File: rtl/rs_dwell_timer.sv
module rs_dwell_timer #(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [DWELL_W-1:0] dwell_cycles,
    output logic               expire
);
    logic [DWELL_W-1:0] cnt_q;
    logic [DWELL_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign expire  = run && (cnt_inc >= {1'b0, dwell_cycles});

    always_ff @(posedge clk) begin
        if (rst || !run || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_inc[DWELL_W-1:0];
    end

    // R6: the count restarts whenever stepping is not running
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/rate_seeker.sv
module rate_seeker
    import rs_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int DWELL_W    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               edge_strobe,
    input  logic               locked,
    input  logic               seek_req,
    input  logic               auto_mode,
    input  logic               mute_en,
    input  logic [1:0]         rate_in,
    input  logic [DWELL_W-1:0] dwell_cycles,
    output logic [1:0]         rate_out,
    output logic               rate_drive_en,
    output logic               carrier_ok,
    output logic               seeking,
    output logic               hold_out
);
    rs_state_e state_q, state_d;
    logic [1:0] rate_q;
    logic       hold_q;
    logic       dwell_up;
    logic       in_seek;

    assign in_seek = (state_q == ST_SEEK);

    rs_carrier_timer #(.CYC_PER_US(CYC_PER_US)) u_carrier (
        .clk         (clk),
        .rst         (rst),
        .edge_strobe (edge_strobe),
        .present     (carrier_ok)
    );

    rs_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
        .clk          (clk),
        .rst          (rst),
        .run          (in_seek),
        .dwell_cycles (dwell_cycles),
        .expire       (dwell_up)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!auto_mode) begin
            state_d = ST_MANUAL;
        end else begin
            unique case (state_q)
                ST_MANUAL:  state_d = carrier_ok ? ST_SEEK : ST_INHIBIT;
                ST_IDLE:    if (seek_req) state_d = carrier_ok ? ST_SEEK : ST_INHIBIT;
                ST_SEEK:    if (locked) state_d = ST_IDLE;
                            else if (!carrier_ok) state_d = ST_INHIBIT;
                ST_INHIBIT: if (locked) state_d = ST_IDLE;
                            else if (carrier_ok) state_d = ST_SEEK;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // rate register and hold strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= 2'd0;
            hold_q <= 1'b0;
        end else begin
            hold_q <= mute_en && !carrier_ok;
            if (!auto_mode)
                rate_q <= rate_in;
            else if (in_seek && !locked && carrier_ok && dwell_up)
                rate_q <= rate_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        rate_out      = rate_q;
        hold_out      = hold_q;
        rate_drive_en = (state_q != ST_MANUAL);
        seeking       = (state_q == ST_SEEK) || (state_q == ST_INHIBIT);
    end

    // R2: in automatic mode the rate either holds or moves one step forward
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && state_q != ST_MANUAL) |=>
            (rate_out == $past(rate_out) || rate_out == $past(rate_out) + 2'd1));
    // R4: lock freezes the rate and ends the search
    p_lock_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && in_seek && locked) |=> (rate_out == $past(rate_out) && !seeking));
    // R6: no stepping while the search is inhibited
    p_inhibit_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && state_q == ST_INHIBIT) |=> rate_out == $past(rate_out));
    // R7: muted loss of carrier raises the hold strobe
    p_hold_on_loss_r7: assert property (@(posedge clk) disable iff (rst)
        (mute_en && !carrier_ok) |=> hold_out);
    // R8: manual mode releases the bus and samples it
    p_manual_load_r8: assert property (@(posedge clk) disable iff (rst)
        !auto_mode |=> (!rate_drive_en && rate_out == $past(rate_in)));
endmodule

// File: tb/rate_seeker_bench.sv
module rate_seeker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_US       = 6;
    localparam int DW         = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          edge_strobe = 1'b0;
    logic          locked = 1'b0;
    logic          seek_req = 1'b0;
    logic          auto_mode = 1'b0;
    logic          mute_en = 1'b0;
    logic [1:0]    rate_in = 2'd0;
    logic [DW-1:0] dwell_cycles = '0;
    logic [1:0]    rate_out;
    logic          rate_drive_en, carrier_ok, seeking, hold_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model; state codes 0 manual, 1 idle, 2 seek, 3 inhibit
    int       m_cc = 0;
    int       m_st = 1;
    int       m_dc = 0;
    int       m_rate = 0;
    bit       m_hold = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_seeker #(.CYC_PER_US(T_US), .DWELL_W(DW)) u_rate_seeker (
        .clk(clk), .rst(rst), .edge_strobe(edge_strobe), .locked(locked),
        .seek_req(seek_req), .auto_mode(auto_mode), .mute_en(mute_en),
        .rate_in(rate_in), .dwell_cycles(dwell_cycles), .rate_out(rate_out),
        .rate_drive_en(rate_drive_en), .carrier_ok(carrier_ok),
        .seeking(seeking), .hold_out(hold_out)
    );

    task automatic model_step();
        bit car = (m_cc != 0);
        int eff = (dwell_cycles == 0) ? 1 : int'(dwell_cycles);
        bit tick = (m_st == 2) && (m_dc + 1 >= eff);
        int nst = m_st;
        if (rst) begin
            m_cc = 0; m_st = 1; m_dc = 0; m_rate = 0; m_hold = 0;
            return;
        end
        if (!auto_mode) nst = 0;
        else case (m_st)
            0: nst = car ? 2 : 3;
            1: if (seek_req) nst = car ? 2 : 3;
            2: if (locked) nst = 1; else if (!car) nst = 3;
            default: if (locked) nst = 1; else if (car) nst = 2;
        endcase
        if (!auto_mode) m_rate = int'(rate_in);
        else if (m_st == 2 && !locked && car && tick) m_rate = (m_rate + 1) % 4;
        m_dc   = (m_st != 2 || tick) ? 0 : m_dc + 1;
        m_hold = mute_en && !car;
        if (edge_strobe) m_cc = T_US; else if (m_cc > 0) m_cc--;
        m_st = nst;
    endtask

    task automatic cmp(string tag, string what, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp(tag, "rate_out", int'(rate_out), m_rate);
        cmp("R5", "carrier_ok", int'(carrier_ok), int'(m_cc != 0));
        cmp("R11", "seeking", int'(seeking), int'(m_st >= 2));
        cmp("R7", "hold_out", int'(hold_out), int'(m_hold));
        cmp("R8", "rate_drive_en", int'(rate_drive_en), int'(m_st != 0));
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        repeat (2) cyc("R1");
        cmp("R1", "reset rate", int'(rate_out), 0);
        cmp("R1", "reset seeking", int'(seeking), 0);
        rst = 1'b0;

        // sweep of dwell length against starting rate
        for (int dw = 0; dw < 5; dw++) begin
            for (int r0 = 0; r0 < 4; r0++) begin
                int eff = (dw == 0) ? 1 : dw;
                dwell_cycles = DW'(dw);
                auto_mode = 1'b0; rate_in = 2'(r0); edge_strobe = 1'b1;
                repeat (2) cyc("R8");
                auto_mode = 1'b1; rate_in = 2'(r0 + 1);
                cyc("R9");
                repeat (4 * eff + 2) cyc(dw == 0 ? "R10" : "R2");
                locked = 1'b1;
                repeat (3) cyc("R4");
                locked = 1'b0;
                repeat (2) cyc("R4");
                seek_req = 1'b1; cyc("R3"); seek_req = 1'b0;
                repeat (2 * eff + 1) cyc("R3");
                edge_strobe = 1'b0; mute_en = r0[0];
                repeat (T_US + 4) cyc(mute_en ? "R7" : "R6");
                edge_strobe = 1'b1;
                repeat (2 * eff + 2) cyc("R6");
                mute_en = 1'b0;
            end
        end

        // carrier gap sweep around the timeout
        locked = 1'b1; dwell_cycles = DW'(2);
        for (int gap = 1; gap <= T_US + 2; gap++) begin
            for (int k = 0; k < 3; k++) begin
                edge_strobe = 1'b1; cyc("R5");
                edge_strobe = 1'b0;
                repeat (gap - 1) cyc("R5");
            end
        end
        locked = 1'b0;

        // pseudo-random mix
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            edge_strobe  = (lfsr[3:0] < 4'd5);
            locked       = (lfsr[9:5] == 5'd0) ? ~locked : locked;
            seek_req     = (lfsr[7:4] == 4'd3);
            auto_mode    = (lfsr[15:10] != 6'd0);
            mute_en      = lfsr[11];
            rate_in      = lfsr[2:1];
            dwell_cycles = DW'(lfsr[14:13]);
            cyc("R2");
        end

        rst = 1'b1; cyc("R1"); rst = 1'b0;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule